// File: doc/BRIEF.md
# Byte-Stream Frame Inverter with Length Statistics

This block sits in a byte-wide frame path. Frames enter one byte per clock, marked by a valid strobe. Each frame leaves on an output stream of the same format one cycle later. A control bit held in a small register bank decides whether the frame is copied as it is or has every byte complemented. The complement covers the header, the payload and the trailing check bytes alike.

Alongside the data path, a 32-bit statistics counter adds up the number of bytes in each frame that passes. Software reads the counter as two 16-bit words and clears any of its bits by writing ones. Software uses a plain parallel register bus with an address, write and read strobes, and 16-bit write and read data. Read data appears on the cycle after the read strobe.

Top module: `frame_xor_stats`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock, and each output byte appears one clock after its input byte.
- R2: The control register sits at word address 0x9. Bit 0 is the invert enable and is read/write. Reads return it in bit 0 with all other bits 0.
- R3: While a frame's invert setting is 1, each output byte is the input byte XOR 0xFF. While it is 0, each output byte equals the input byte.
- R4: The invert setting is taken from the control bit at the first byte of a frame. A change written during the frame takes effect from the next frame.
- R5: When a frame ends, the counter grows by the number of valid bytes in that frame. A frame ends at the first clock edge where `in_valid` is low after being high. The new value is readable from the next read strobe on.
- R6: The counter is mapped big-endian: bits 31:16 at word address 0x5, bits 15:0 at word address 0x6. Between updates it holds its value.
- R7: A write to either counter word clears each counter bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R8: If a counter clear and a frame-end update fall on the same edge, the clear acts on the old value and the frame length is added afterwards.
- R9: `reg_rdata` carries the addressed value on the cycle after `reg_rd` is high and is 0 otherwise. Unmapped addresses read 0, and writes to them change neither the control bit nor the counter.
- R10: While `rst_n` is low, the invert bit, the counter and `out_valid` are forced to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input byte qualifier; high for the length of a frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output byte qualifier |
| out_data | output | 8 | Output byte, possibly complemented |
| reg_addr | input | 16 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid the cycle after `reg_rd` |

## Verification
The assertions assume that frames are separated by at least one idle cycle. They also assume that a read and a write never share a cycle, so each read returns the state as it stood before that edge. The stimulus issues register accesses one at a time, always leaves an idle gap between frames, and times its writes against frame boundaries. It places one control write in the middle of a frame and one counter clear exactly on the edge where a frame ends. A frame longer than 65536 bytes pushes a carry into the upper counter word, so the big-endian split is seen with both halves non-zero.

// File: rtl/fxs_pkg.sv
package fxs_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] fxs_byte_t;
endpackage

// File: rtl/fxs_stream_path.sv
module fxs_stream_path
   import fxs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      in_valid,
   input  fxs_byte_t in_data,
   input  logic      inv_cfg,
   output logic      out_valid,
   output fxs_byte_t out_data,
   output logic      frame_start,
   output logic      frame_end
);
   logic prev_v;
   logic held_inv;
   logic use_inv;

   assign frame_start = in_valid & ~prev_v;
   assign frame_end   = ~in_valid & prev_v;
   // first byte takes the live setting, later bytes the latched one
   assign use_inv     = frame_start ? inv_cfg : held_inv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_v    <= 1'b0;
         held_inv  <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         prev_v    <= in_valid;
         out_valid <= in_valid;
         if (frame_start) held_inv <= inv_cfg;
         if (in_valid)    out_data <= in_data ^ {BYTE_W{use_inv}};
      end
   end

   // R1: a byte in becomes a byte out one clock later
   p_lat_on_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_lat_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R3: plain first byte comes out untouched
   p_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && !inv_cfg) |=> (out_data == $past(in_data)));
endmodule

// File: rtl/fxs_len_counter.sv
module fxs_len_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             frame_start,
   input  logic             frame_end,
   input  logic [CNT_W-1:0] clr_mask,
   output logic [CNT_W-1:0] cnt
);
   logic [CNT_W-1:0] len_run;
   logic [CNT_W-1:0] cnt_kept;

   assign cnt_kept = cnt & ~clr_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_run <= '0;
         cnt     <= '0;
      end else begin
         if (frame_start)   len_run <= CNT_W'(1);
         else if (in_valid) len_run <= len_run + 1'b1;
         // clear first, then fold in the finished frame
         if (frame_end) cnt <= cnt_kept + len_run;
         else           cnt <= cnt_kept;
      end
   end

   // R6: no frame end and no clear leaves the counter alone
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_end && (clr_mask == '0)) |=> $stable(cnt));
   // R7: cleared bits read back as zero
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_end && (clr_mask != '0)) |=> ((cnt & $past(clr_mask)) == '0));
endmodule

// File: rtl/fxs_regbank.sv
module fxs_regbank #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned BUS_W     = 16,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned CTRL_ADDR = 9,
   parameter int unsigned CNT_BASE  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [BUS_W-1:0]  reg_wdata,
   input  logic [CNT_W-1:0]  cnt,
   output logic [BUS_W-1:0]  reg_rdata,
   output logic              inv_cfg,
   output logic [CNT_W-1:0]  clr_mask
);
   localparam int unsigned NWORDS = CNT_W / BUS_W;

   if (CNT_W % BUS_W != 0) begin : g_bad_split
      $error("counter width must be a multiple of the bus width");
   end
   if (CTRL_ADDR >= CNT_BASE && CTRL_ADDR < CNT_BASE + NWORDS) begin : g_bad_map
      $error("control address overlaps the counter words");
   end

   logic [BUS_W-1:0] cnt_word [NWORDS];
   logic [NWORDS-1:0] word_hit;
   logic              ctrl_hit;
   logic              mapped;
   logic [BUS_W-1:0]  rd_val;

   assign ctrl_hit = (reg_addr == ADDR_W'(CTRL_ADDR));
   assign mapped   = ctrl_hit | (|word_hit);

   // word 0 holds the most significant slice
   for (genvar k = 0; k < NWORDS; k++) begin : g_word
      localparam int unsigned SH = (NWORDS - 1 - k) * BUS_W;
      assign word_hit[k]          = (reg_addr == ADDR_W'(CNT_BASE + k));
      assign cnt_word[k]          = cnt[SH +: BUS_W];
      assign clr_mask[SH +: BUS_W] = (reg_wr && word_hit[k]) ? reg_wdata : '0;
   end

   always_comb begin
      rd_val = '0;
      if (ctrl_hit) rd_val[0] = inv_cfg;
      for (int k = 0; k < NWORDS; k++) begin
         if (word_hit[k]) rd_val = cnt_word[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inv_cfg   <= 1'b0;
         reg_rdata <= '0;
      end else begin
         reg_rdata <= reg_rd ? rd_val : '0;
         if (reg_wr && ctrl_hit) inv_cfg <= reg_wdata[0];
      end
   end

   // R2: control writes land in bit 0
   p_ctrl_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && ctrl_hit) |=> (inv_cfg == $past(reg_wdata[0])));
   // R9: read bus idles at zero without a strobe
   p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> (reg_rdata == '0));
   p_rd_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !mapped) |=> (reg_rdata == '0));
   p_wr_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !mapped) |=> $stable(inv_cfg));
endmodule

// File: rtl/frame_xor_stats.sv
module frame_xor_stats
   import fxs_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned BUS_W     = 16,
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned CTRL_ADDR = 9,
   parameter int unsigned CNT_BASE  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_data,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [BUS_W-1:0]  reg_wdata,
   output logic [BUS_W-1:0]  reg_rdata
);
   logic             inv_cfg;
   logic             frame_start;
   logic             frame_end;
   logic [CNT_W-1:0] clr_mask;
   logic [CNT_W-1:0] cnt;

   fxs_stream_path u_path (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_data     (in_data),
      .inv_cfg     (inv_cfg),
      .out_valid   (out_valid),
      .out_data    (out_data),
      .frame_start (frame_start),
      .frame_end   (frame_end)
   );

   fxs_len_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .frame_start (frame_start),
      .frame_end   (frame_end),
      .clr_mask    (clr_mask),
      .cnt         (cnt)
   );

   fxs_regbank #(
      .ADDR_W    (ADDR_W),
      .BUS_W     (BUS_W),
      .CNT_W     (CNT_W),
      .CTRL_ADDR (CTRL_ADDR),
      .CNT_BASE  (CNT_BASE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_wdata (reg_wdata),
      .cnt       (cnt),
      .reg_rdata (reg_rdata),
      .inv_cfg   (inv_cfg),
      .clr_mask  (clr_mask)
   );
endmodule

// File: tb/frame_xor_stats_test.sv
module frame_xor_stats_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = '0;
   logic        out_valid;
   logic [7:0]  out_data;
   logic [15:0] reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;

   int checks = 0;
   int errors = 0;
   string dtag = "R3";
   string rtag = "R2";

   always #2 clk = ~clk;

   frame_xor_stats uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // behavioural reference, stepped once per clock edge
   bit          m_prev, m_inv, m_finv;
   logic [31:0] m_cnt, m_len;

   function automatic logic [15:0] m_read(input logic [15:0] a);
      case (a)
         16'h9:   return {15'b0, m_inv};
         16'h5:   return m_cnt[31:16];
         16'h6:   return m_cnt[15:0];
         default: return 16'h0;
      endcase
   endfunction

   always begin
      bit          exp_v, first, fend;
      logic [7:0]  exp_d;
      logic [15:0] exp_rd;
      logic [31:0] mask;
      string       vtag, rt;
      @(posedge clk);
      if (!rst_n) begin
         m_prev = 0; m_inv = 0; m_finv = 0; m_cnt = '0; m_len = '0;
         exp_v = 0; exp_d = '0; exp_rd = '0; vtag = "R10"; rt = "R10";
      end else begin
         vtag   = "R1";
         exp_v  = in_valid;
         exp_rd = reg_rd ? m_read(reg_addr) : 16'h0;
         rt     = reg_rd ? rtag : "R9";
         first  = in_valid && !m_prev;
         fend   = !in_valid && m_prev;
         if (first) m_finv = m_inv;
         exp_d  = in_data ^ {8{m_finv}};
         mask   = '0;
         if (reg_wr && reg_addr == 16'h5) mask = {reg_wdata, 16'h0};
         if (reg_wr && reg_addr == 16'h6) mask = {16'h0, reg_wdata};
         m_cnt = m_cnt & ~mask;
         if (fend) m_cnt = m_cnt + m_len;
         if (in_valid) m_len = first ? 32'd1 : m_len + 32'd1;
         if (reg_wr && reg_addr == 16'h9) m_inv = reg_wdata[0];
         m_prev = in_valid;
      end
      #1;
      check(out_valid == exp_v, vtag, "out_valid", {31'b0, out_valid}, {31'b0, exp_v});
      if (exp_v) check(out_data == exp_d, dtag, "out_data", {24'b0, out_data}, {24'b0, exp_d});
      check(reg_rdata == exp_rd, rt, "reg_rdata", {16'b0, reg_rdata}, {16'b0, exp_rd});
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 0; reg_wr = 0; reg_rd = 0;
      end
   endtask

   task automatic reg_write(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1; reg_rd = 0;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic reg_read(input logic [15:0] a, input string tag);
      @(negedge clk);
      rtag = tag; reg_addr = a; reg_rd = 1; reg_wr = 0;
      @(negedge clk);
      reg_rd = 0;
      @(negedge clk);
   endtask

   // wr_at: byte index carrying a register write (-1 none); clr_end: clear
   // low word on the first idle edge
   task automatic send_frame(input int len, input logic [7:0] seed, input int wr_at,
                             input logic [15:0] wa, input logic [15:0] wd, input bit clr_end);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1; in_data = seed + 8'(i * 7);
         reg_wr = (i == wr_at); reg_addr = wa; reg_wdata = wd;
      end
      @(negedge clk);
      in_valid = 0;
      reg_wr = clr_end; reg_addr = 16'h6; reg_wdata = 16'hFFFF;
      @(negedge clk);
      reg_wr = 0;
   endtask

   initial begin
      #(4 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(4);
      @(negedge clk); rst_n = 1;
      // R10 / R2: reset values through the bus
      reg_read(16'h9, "R10");
      reg_read(16'h5, "R10");
      reg_read(16'h6, "R10");
      // R3 plain pass-through, R5 length accumulation
      dtag = "R3";
      send_frame(20, 8'h11, -1, 16'h0, 16'h0, 0);
      reg_read(16'h6, "R5");
      // R2 control write and readback, R3 inverted frame
      reg_write(16'h9, 16'hFFFF);
      reg_read(16'h9, "R2");
      send_frame(64, 8'hA5, -1, 16'h0, 16'h0, 0);
      reg_read(16'h6, "R5");
      // R4: control cleared mid-frame, current frame stays inverted
      dtag = "R4";
      send_frame(30, 8'h3C, 10, 16'h9, 16'h0000, 0);
      send_frame(12, 8'h77, -1, 16'h0, 16'h0, 0);
      reg_read(16'h9, "R4");
      // R7: selective write-one-to-clear on the low word
      dtag = "R3";
      reg_write(16'h6, 16'h0012);
      reg_read(16'h6, "R7");
      reg_write(16'h5, 16'hFFFF);
      reg_read(16'h6, "R7");
      // R6: long frame carries into the upper word
      send_frame(70000, 8'h01, -1, 16'h0, 16'h0, 0);
      reg_read(16'h5, "R6");
      reg_read(16'h6, "R6");
      reg_write(16'h5, 16'h0001);
      reg_read(16'h5, "R7");
      // R8: clear on the same edge as the frame end
      send_frame(25, 8'h5A, -1, 16'h0, 16'h0, 1);
      reg_read(16'h6, "R8");
      reg_read(16'h5, "R8");
      // R9: unmapped reads and writes
      reg_read(16'h7, "R9");
      reg_read(16'h0, "R9");
      reg_write(16'h7, 16'hFFFF);
      reg_write(16'h4, 16'hFFFF);
      reg_read(16'h9, "R9");
      reg_read(16'h6, "R9");
      reg_read(16'h5, "R9");
      idle(4);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule